// File: doc/BRIEF.md
# Segment Descriptor Address Translator

This block turns a segment number and an offset into a memory address for four segment slots: code (0), data (1), stack (2) and extra (3). Each slot is given a value by a load request. In real addressing the loaded value itself is the segment: it is shifted left by four and added to a 16-bit offset. The result wraps inside a 20-bit (1 MB) space.

In protected addressing the loaded value is a selector. Its upper 13 bits index an 8-byte descriptor, and bit 2 picks the local table (set) or the global table (clear). Each table has its own base and limit register, written through a small table port. The block reads the eight descriptor bytes one at a time over a byte-wide memory read port. It keeps the decoded base, limit and present bit as a private copy for that slot. Accesses then need no table read. An access adds its offset to the copied base after checking the offset against the copied limit and the present bit.

Loads are accepted one at a time. An access to a slot whose copy is being refilled is held off through `acc_ready`. Every accepted access gives one registered result: either an address, or a fault with the address forced to zero.

Top module: `seg_xlate`

## Requirements
- R1: After reset `ld_busy`, `ld_done`, `mem_req` and `out_valid` are low, and `acc_ready` is low for every slot.
- R2: A load with `mode_prot` low issues no memory read. It raises `ld_done`, with `ld_err` low, in the cycle after acceptance, and the slot then holds a real-mode segment equal to `ld_sel`.
- R3: For a real-mode slot the address is `(seg << 4) + offset` modulo 2^20, with bits 31:20 zero, and the access never faults.
- R4: A protected load reads the descriptor at table base + 8 × `ld_sel[15:3]`, from the local table when `ld_sel[2]` is 1 and the global table when it is 0. It reads the eight bytes at consecutive rising addresses, with `mem_req` high for one cycle per byte and the next request only after `mem_rvalid`. It then raises `ld_done` with `ld_err` low.
- R5: If 8 × index + 7 exceeds the chosen table's limit, the load issues no read. It raises `ld_done` and `ld_err` in the cycle after acceptance, and every later access to that slot faults.
- R6: Descriptor bytes 0–3 are the segment base, least significant byte first. Bytes 4–5 are the limit, low byte first. Bit 7 of byte 6 is the present flag. Byte 7 is ignored.
- R7: For a protected slot with the present flag set and offset ≤ limit, the address is base + offset modulo 2^32, with no fault.
- R8: For a protected slot, an offset above the limit or a clear present flag gives `out_fault` high and `out_addr` zero.
- R9: `acc_ready` for a slot is low from the acceptance of a protected load into that slot until its `ld_done`. An accepted access (`acc_req` and `acc_ready`) gives `out_valid` exactly one cycle later, and only then.
- R10: The four slots are independent: loading one leaves the translations of the others unchanged.
- R11: A write with `tbl_we` sets the base and limit of the local table when `tbl_sel` is 1 and of the global table when it is 0, and leaves the other table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_prot | input | 1 | Addressing mode for a load: 1 protected, 0 real |
| tbl_we | input | 1 | Table register write strobe |
| tbl_sel | input | 1 | Table written: 1 local, 0 global |
| tbl_base | input | 32 | Table base address to write |
| tbl_limit | input | 16 | Table byte limit to write |
| ld_valid | input | 1 | Load request, accepted when `ld_busy` is low |
| ld_seg | input | 2 | Slot to load: 0 code, 1 data, 2 stack, 3 extra |
| ld_sel | input | 16 | Segment value or selector |
| ld_busy | output | 1 | Descriptor fetch in progress |
| ld_done | output | 1 | One-cycle pulse when a load completes |
| ld_err | output | 1 | With `ld_done`: selector outside its table |
| acc_req | input | 1 | Access request |
| acc_seg | input | 2 | Slot used by the access |
| acc_ofs | input | 16 | Offset within the segment |
| acc_ready | output | 1 | The slot named by `acc_seg` holds a usable copy |
| out_valid | output | 1 | Result valid, one cycle after acceptance |
| out_fault | output | 1 | Access faulted |
| out_addr | output | 32 | Translated address, zero on fault |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 32 | Byte read address |
| mem_rdata | input | 8 | Read data |
| mem_rvalid | input | 1 | Read data valid |

## Verification
The bench aims at the ends of each range. An offset equal to the limit must pass and the next value must fault, so an off-by-one limit compare shows as a wrong fault bit. A real-mode sum past 1 MB must wrap to a low address, so a translator that keeps a carry shows bit 20 set. Similar ends come from a descriptor base near the top of the 32-bit space and from a selector whose last descriptor byte lands exactly on the table limit, or one entry past it. Directed descriptors with a clear present flag, local-versus-global table choice, and reloads of one slot between accesses to another expose a swapped table, an ignored present bit, or copies that leak between slots. Random memory latency checks that the byte order and the read addresses do not depend on timing.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int BASE_W  = 32;
  localparam int LIM_W   = 16;
  localparam int SEL_W   = 16;
  localparam int OFS_W   = 16;
  localparam int REAL_W  = 20;
  localparam int IDX_W   = SEL_W - 3;
  localparam int BYTES_W = 3;

  typedef struct packed {
    logic              valid;
    logic              real_m;
    logic              present;
    logic [LIM_W-1:0]  limit;
    logic [BASE_W-1:0] base;
  } shadow_t;

  typedef enum logic [1:0] {FS_IDLE, FS_REQ, FS_WAIT} fstate_t;
endpackage

// File: rtl/seg_table_regs.sv
module seg_table_regs
  import seg_xlate_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tbl_we,
  input  logic                        tbl_sel,
  input  logic [BASE_W-1:0]           tbl_base,
  input  logic [LIM_W-1:0]            tbl_limit,
  output logic [1:0][BASE_W-1:0]      tb_base,
  output logic [1:0][LIM_W-1:0]       tb_limit
);
  for (genvar t = 0; t < 2; t++) begin : g_tbl
    logic en;
    assign en = tbl_we && (tbl_sel == t[0]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tb_base[t]  <= '0;
        tb_limit[t] <= '0;
      end else if (en) begin
        tb_base[t]  <= tbl_base;
        tb_limit[t] <= tbl_limit;
      end
    end
  end
endmodule

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_prot,
  input  logic                   ld_valid,
  input  logic [SEG_W-1:0]       ld_seg,
  input  logic [SEL_W-1:0]       ld_sel,
  input  logic [1:0][BASE_W-1:0] tb_base,
  input  logic [1:0][LIM_W-1:0]  tb_limit,
  output logic                   ld_busy,
  output logic                   ld_done,
  output logic                   ld_err,
  output logic                   mem_req,
  output logic [BASE_W-1:0]      mem_addr,
  input  logic [7:0]             mem_rdata,
  input  logic                   mem_rvalid,
  output logic                   inv_we,
  output logic                   sh_we,
  output logic [SEG_W-1:0]       sh_idx,
  output shadow_t                sh_data
);
  localparam int BUF_W = 7 * 8;

  fstate_t              st_q, st_d;
  logic [BYTES_W-1:0]   cnt_q, cnt_d;
  logic [BASE_W-1:0]    dba_q, dba_d;
  logic [SEG_W-1:0]     seg_q, seg_d;
  logic [BUF_W-1:0]     dbuf_q;
  logic                 done_d, err_d;

  logic                 accept, tsel, oob, fetch_go, last_byte, shift_en;
  logic [IDX_W-1:0]     idx;
  logic [LIM_W-1:0]     end_ofs;

  assign accept    = ld_valid && (st_q == FS_IDLE);
  assign tsel      = ld_sel[2];
  assign idx       = ld_sel[SEL_W-1:3];
  assign end_ofs   = {idx, 3'b111};
  assign oob       = end_ofs > tb_limit[tsel];
  assign fetch_go  = accept && mode_prot && !oob;
  assign last_byte = (st_q == FS_WAIT) && mem_rvalid && (cnt_q == '1);
  assign shift_en  = (st_q == FS_WAIT) && mem_rvalid && (cnt_q != '1);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    dba_d = dba_q;
    seg_d = seg_q;
    case (st_q)
      FS_IDLE: if (fetch_go) begin
        st_d  = FS_REQ;
        cnt_d = '0;
        dba_d = tb_base[tsel] + {{(BASE_W-IDX_W-3){1'b0}}, idx, 3'b000};
        seg_d = ld_seg;
      end
      FS_REQ:  st_d = FS_WAIT;
      FS_WAIT: if (mem_rvalid) begin
        st_d  = (cnt_q == '1) ? FS_IDLE : FS_REQ;
        cnt_d = cnt_q + 1'b1;
      end
      default: st_d = FS_IDLE;
    endcase
  end

  assign done_d = (accept && !fetch_go) || last_byte;
  assign err_d  = accept && mode_prot && oob;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= FS_IDLE;
      cnt_q   <= '0;
      dba_q   <= '0;
      seg_q   <= '0;
      ld_done <= 1'b0;
      ld_err  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      dba_q   <= dba_d;
      seg_q   <= seg_d;
      ld_done <= done_d;
      ld_err  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dbuf_q <= '0;
    else if (shift_en) dbuf_q <= {mem_rdata, dbuf_q[BUF_W-1:8]};
  end

  assign ld_busy  = (st_q != FS_IDLE);
  assign mem_req  = (st_q == FS_REQ);
  assign mem_addr = dba_q + {{(BASE_W-BYTES_W){1'b0}}, cnt_q};

  // Shadow write: real value or table miss at acceptance, descriptor on last byte.
  always_comb begin
    inv_we  = fetch_go;
    sh_we   = (accept && !fetch_go) || last_byte;
    sh_idx  = last_byte ? seg_q : ld_seg;
    sh_data = '0;
    if (last_byte) begin
      sh_data.valid   = 1'b1;
      sh_data.real_m  = 1'b0;
      sh_data.present = dbuf_q[55];
      sh_data.limit   = dbuf_q[47:32];
      sh_data.base    = dbuf_q[31:0];
    end else if (!mode_prot) begin
      sh_data.valid   = 1'b1;
      sh_data.real_m  = 1'b1;
      sh_data.present = 1'b1;
      sh_data.limit   = '1;
      sh_data.base    = {{(BASE_W-SEL_W-4){1'b0}}, ld_sel, 4'b0000};
    end else begin
      sh_data.valid   = 1'b1;
    end
  end
endmodule

// File: rtl/seg_shadow_bank.sv
module seg_shadow_bank
  import seg_xlate_pkg::*;
#(
  parameter int NSEG  = 4,
  parameter int SEG_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inv_we,
  input  logic                 sh_we,
  input  logic [SEG_W-1:0]     sh_idx,
  input  shadow_t              sh_data,
  output shadow_t [NSEG-1:0]   sh_rd
);
  for (genvar s = 0; s < NSEG; s++) begin : g_slot
    logic hit, wr_en, inv_en;
    assign hit    = (sh_idx == s[SEG_W-1:0]);
    assign wr_en  = hit && sh_we;
    assign inv_en = hit && inv_we && !sh_we;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sh_rd[s]       <= '0;
      else if (wr_en)  sh_rd[s]       <= sh_data;
      else if (inv_en) sh_rd[s].valid <= 1'b0;
    end
  end
endmodule

// File: rtl/seg_addr_calc.sv
module seg_addr_calc
  import seg_xlate_pkg::*;
#(
  parameter int NSEG  = 4,
  parameter int SEG_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  shadow_t [NSEG-1:0]   sh_rd,
  input  logic                 acc_req,
  input  logic [SEG_W-1:0]     acc_seg,
  input  logic [OFS_W-1:0]     acc_ofs,
  output logic                 acc_ready,
  output logic                 out_valid,
  output logic                 out_fault,
  output logic [BASE_W-1:0]    out_addr
);
  shadow_t            cur;
  logic               fire, flt_d;
  logic [BASE_W-1:0]  addr_d;
  logic [REAL_W-1:0]  real_sum;

  assign cur       = sh_rd[acc_seg];
  assign acc_ready = cur.valid;
  assign fire      = acc_req && acc_ready;
  assign real_sum  = cur.base[REAL_W-1:0] + {{(REAL_W-OFS_W){1'b0}}, acc_ofs};

  always_comb begin
    if (cur.real_m) begin
      flt_d  = 1'b0;
      addr_d = {{(BASE_W-REAL_W){1'b0}}, real_sum};
    end else begin
      flt_d  = (acc_ofs > cur.limit) || !cur.present;
      addr_d = flt_d ? '0 : cur.base + {{(BASE_W-OFS_W){1'b0}}, acc_ofs};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_fault <= 1'b0;
      out_addr  <= '0;
    end else if (fire) begin
      out_fault <= flt_d;
      out_addr  <= addr_d;
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter  int NSEG  = 4,
  localparam int SEG_W = $clog2(NSEG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_prot,
  input  logic               tbl_we,
  input  logic               tbl_sel,
  input  logic [31:0]        tbl_base,
  input  logic [15:0]        tbl_limit,
  input  logic               ld_valid,
  input  logic [SEG_W-1:0]   ld_seg,
  input  logic [15:0]        ld_sel,
  output logic               ld_busy,
  output logic               ld_done,
  output logic               ld_err,
  input  logic               acc_req,
  input  logic [SEG_W-1:0]   acc_seg,
  input  logic [15:0]        acc_ofs,
  output logic               acc_ready,
  output logic               out_valid,
  output logic               out_fault,
  output logic [31:0]        out_addr,
  output logic               mem_req,
  output logic [31:0]        mem_addr,
  input  logic [7:0]         mem_rdata,
  input  logic               mem_rvalid
);
  logic [1:0]              rs_q;
  logic                    rst_i_n;
  logic [1:0][BASE_W-1:0]  tb_base;
  logic [1:0][LIM_W-1:0]   tb_limit;
  logic                    inv_we, sh_we;
  logic [SEG_W-1:0]        sh_idx;
  shadow_t                 sh_data;
  shadow_t [NSEG-1:0]      sh_rd;

  // Reset asserts at once and is released two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  seg_table_regs u_tbl (
    .clk(clk), .rst_n(rst_i_n), .tbl_we(tbl_we), .tbl_sel(tbl_sel),
    .tbl_base(tbl_base), .tbl_limit(tbl_limit),
    .tb_base(tb_base), .tb_limit(tb_limit)
  );

  seg_desc_fetch #(.SEG_W(SEG_W)) u_fetch (
    .clk(clk), .rst_n(rst_i_n), .mode_prot(mode_prot),
    .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_sel(ld_sel),
    .tb_base(tb_base), .tb_limit(tb_limit),
    .ld_busy(ld_busy), .ld_done(ld_done), .ld_err(ld_err),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .inv_we(inv_we), .sh_we(sh_we), .sh_idx(sh_idx), .sh_data(sh_data)
  );

  seg_shadow_bank #(.NSEG(NSEG), .SEG_W(SEG_W)) u_bank (
    .clk(clk), .rst_n(rst_i_n), .inv_we(inv_we), .sh_we(sh_we),
    .sh_idx(sh_idx), .sh_data(sh_data), .sh_rd(sh_rd)
  );

  seg_addr_calc #(.NSEG(NSEG), .SEG_W(SEG_W)) u_calc (
    .clk(clk), .rst_n(rst_i_n), .sh_rd(sh_rd),
    .acc_req(acc_req), .acc_seg(acc_seg), .acc_ofs(acc_ofs),
    .acc_ready(acc_ready), .out_valid(out_valid),
    .out_fault(out_fault), .out_addr(out_addr)
  );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ld_valid,
  input logic        ld_busy,
  input logic        ld_done,
  input logic        ld_err,
  input logic        acc_req,
  input logic        acc_ready,
  input logic        out_valid,
  input logic        out_fault,
  input logic [31:0] out_addr,
  input logic        mem_req
);
  // R8: a faulting result carries no address
  p_fault_no_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fault) |-> (out_addr == 32'd0));

  // R9: accepted access yields a result next cycle
  p_result_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_ready) |=> out_valid);

  // R9: no result without an accepted access
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_req && acc_ready) |=> !out_valid);

  // R4: one request per byte, never back to back
  p_req_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R4: reads happen only during a fetch
  p_req_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ld_busy);

  // R2: completion is reported with the fetch engine idle
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |-> !ld_busy);

  // R5: an error is reported only with completion
  p_err_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_err |-> ld_done);

  // R2: an accepted load either completes next cycle or starts a fetch
  p_load_progress_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !ld_busy) |=> (ld_done || ld_busy));
endmodule

bind seg_xlate seg_xlate_chk u_chk (.*);

// File: tb/seg_xlate_tb_top.sv
`timescale 1ns/1ps
module seg_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_prot, tbl_we, tbl_sel;
  logic [31:0] tbl_base;
  logic [15:0] tbl_limit;
  logic        ld_valid;
  logic [1:0]  ld_seg;
  logic [15:0] ld_sel;
  logic        ld_busy, ld_done, ld_err;
  logic        acc_req;
  logic [1:0]  acc_seg;
  logic [15:0] acc_ofs;
  logic        acc_ready, out_valid, out_fault;
  logic [31:0] out_addr;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        mem_rvalid;

  always #2.5 clk = ~clk;

  seg_xlate dut_i (.*);

  int n_chk = 0;
  int n_err = 0;

  // bench model
  logic [7:0]  mem [logic [31:0]];
  logic [31:0] rd_log [$];
  logic [31:0] m_tbase [2];
  logic [15:0] m_tlim  [2];
  logic        e_val [4];
  logic        e_real[4];
  logic        e_pres[4];
  logic [31:0] e_base[4];
  logic [15:0] e_lim [4];

  function automatic logic [7:0] mem_rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a[7:0] ^ a[15:8] ^ {a[2:0], 5'h0B} ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder: one outstanding read, random latency
  logic        pend;
  logic [31:0] paddr;
  int          dly;
  always @(negedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0; mem_rvalid <= 1'b0; mem_rdata <= '0; dly <= 0;
    end else begin
      mem_rvalid <= 1'b0;
      if (pend) begin
        if (dly == 0) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= mem_rd(paddr);
          pend       <= 1'b0;
        end else dly <= dly - 1;
      end else if (mem_req) begin
        pend  <= 1'b1;
        paddr <= mem_addr;
        dly   <= $urandom % 3;
        rd_log.push_back(mem_addr);
      end
    end
  end

  task automatic put_desc(input logic [31:0] a, input logic [31:0] b,
                          input logic [15:0] l, input logic p);
    mem[a]   = b[7:0];   mem[a+1] = b[15:8];
    mem[a+2] = b[23:16]; mem[a+3] = b[31:24];
    mem[a+4] = l[7:0];   mem[a+5] = l[15:8];
    mem[a+6] = {p, 7'h15};
    mem[a+7] = 8'hC3;
  endtask

  task automatic wr_tbl(input logic sel, input logic [31:0] b, input logic [15:0] l);
    @(negedge clk);
    tbl_we = 1'b1; tbl_sel = sel; tbl_base = b; tbl_limit = l;
    @(negedge clk);
    tbl_we = 1'b0;
    m_tbase[sel] = b; m_tlim[sel] = l;
  endtask

  task automatic do_load(input int seg, input logic [15:0] sel, input logic prot);
    logic        ts, oob;
    logic [31:0] da;
    logic [7:0]  b [8];
    ts  = sel[2];
    oob = ({sel[15:3], 3'b111} > m_tlim[ts]);
    da  = m_tbase[ts] + {16'h0, sel[15:3], 3'b000};
    rd_log.delete();
    @(negedge clk);
    ld_valid = 1'b1; ld_seg = seg[1:0]; ld_sel = sel; mode_prot = prot;
    @(negedge clk);
    ld_valid = 1'b0;
    if (!prot) begin
      chk("R2 real load done", {ld_done, ld_err, ld_busy}, 3'b100);
      e_val[seg] = 1; e_real[seg] = 1; e_pres[seg] = 1;
      e_base[seg] = {12'h0, sel, 4'h0}; e_lim[seg] = 16'hFFFF;
    end else if (oob) begin
      chk("R5 out-of-table load", {ld_done, ld_err, ld_busy}, 3'b110);
      e_val[seg] = 1; e_real[seg] = 0; e_pres[seg] = 0;
      e_base[seg] = 0; e_lim[seg] = 0;
    end else begin
      chk("R4 fetch started", ld_busy, 1'b1);
      acc_seg = seg[1:0]; #1;
      chk("R9 slot held during fetch", acc_ready, 1'b0);
      while (ld_done !== 1'b1) @(negedge clk);
      chk("R4 load ok", {ld_err, ld_busy}, 2'b00);
      chk("R4 read count", rd_log.size(), 8);
      for (int k = 0; k < 8 && k < rd_log.size(); k++)
        chk("R4 read address", rd_log[k], da + k);
      for (int k = 0; k < 8; k++) b[k] = mem_rd(da + k);
      e_val[seg] = 1; e_real[seg] = 0; e_pres[seg] = b[6][7];
      e_base[seg] = {b[3], b[2], b[1], b[0]}; e_lim[seg] = {b[5], b[4]};
    end
    if (!prot || oob) chk("R2 R5 no memory read", rd_log.size(), 0);
  endtask

  task automatic do_acc(input int seg, input logic [15:0] ofs, input string req);
    logic        f;
    logic [31:0] a;
    @(negedge clk);
    acc_req = 1'b1; acc_seg = seg[1:0]; acc_ofs = ofs; #1;
    chk({req, " ready"}, acc_ready, e_val[seg]);
    @(negedge clk);
    acc_req = 1'b0;
    chk({req, " R9 valid"}, out_valid, e_val[seg]);
    if (e_val[seg]) begin
      if (e_real[seg]) begin
        f = 1'b0;
        a = {12'h0, e_base[seg][19:0] + {4'h0, ofs}};
      end else begin
        f = (ofs > e_lim[seg]) || !e_pres[seg];
        a = f ? 32'h0 : e_base[seg] + {16'h0, ofs};
      end
      chk({req, " fault/addr"}, {out_fault, out_addr}, {f, a});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; mode_prot = 0; tbl_we = 0; tbl_sel = 0; tbl_base = 0;
    tbl_limit = 0; ld_valid = 0; ld_seg = 0; ld_sel = 0;
    acc_req = 0; acc_seg = 0; acc_ofs = 0;
    for (int s = 0; s < 4; s++) begin
      e_val[s] = 0; e_real[s] = 0; e_pres[s] = 0; e_base[s] = 0; e_lim[s] = 0;
    end
    m_tbase[0] = 0; m_tbase[1] = 0; m_tlim[0] = 0; m_tlim[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 outputs idle", {ld_busy, ld_done, mem_req, out_valid}, 4'b0000);
    for (int s = 0; s < 4; s++) begin
      acc_seg = s[1:0]; #1;
      chk("R1 slot not ready", acc_ready, 1'b0);
    end

    // R2 R3 real mode, including 1 MB wrap
    do_load(0, 16'hF000, 1'b0);
    do_acc(0, 16'hFFFF, "R3 real top");
    do_load(3, 16'hFFFF, 1'b0);
    do_acc(3, 16'h0010, "R3 real wrap");
    do_acc(3, 16'h0005, "R3 real plain");

    // R11 R4 R6 R7 R8 protected, global table
    put_desc(32'h0000_1010, 32'h0020_0000, 16'h0100, 1'b1);
    put_desc(32'h0000_1008, 32'hFFFF_FFF0, 16'hFFFF, 1'b1);
    put_desc(32'h0000_2008, 32'h0030_0000, 16'h0200, 1'b0);
    wr_tbl(1'b0, 32'h0000_1000, 16'h00FF);
    wr_tbl(1'b1, 32'h0000_2000, 16'h000F);
    do_load(1, 16'h0010, 1'b1);
    do_acc(1, 16'h0100, "R7 offset at limit");
    do_acc(1, 16'h0101, "R8 offset past limit");
    do_load(2, 16'h000B, 1'b1);
    do_acc(2, 16'h0020, "R7 base wrap");
    // R11 local table, last entry fitting the limit, clear present flag
    do_load(2, 16'h000C, 1'b1);
    do_acc(2, 16'h0000, "R8 R11 not present");
    // R10 other slots unchanged
    do_acc(1, 16'h0042, "R10 data slot kept");
    do_acc(0, 16'h1234, "R10 code slot kept");
    // R5 one entry past the local limit
    do_load(3, 16'h0014, 1'b1);
    do_acc(3, 16'h0000, "R5 faulting slot");

    // constrained random mix
    for (int it = 0; it < 150; it++) begin
      int          s;
      logic [15:0] sel, o;
      if ($urandom % 4 == 0)
        wr_tbl($urandom % 2, $urandom & 32'hFFFF_FFF8, 16'($urandom % 16'h200));
      s   = $urandom % 4;
      sel = {13'($urandom % 80), 3'($urandom)};
      if ($urandom % 3 == 0) sel = 16'($urandom);
      do_load(s, sel, ($urandom % 4) != 0);
      for (int k = 0; k < 4; k++) begin
        int t;
        t = $urandom % 4;
        case ($urandom % 4)
          0: o = e_lim[t];
          1: o = e_lim[t] + 16'd1;
          default: o = 16'($urandom);
        endcase
        do_acc(t, o, "R3 R7 R8 R10 random");
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule